// File: doc/BRIEF.md
# Interleaved Banked Byte Memory

This block is a byte-wide memory made of several identical single-port RAM banks placed behind one flat, unsigned address space. Every access address is split into a bank number and an offset within that bank. Only the selected bank is written. A registered bank number picks which bank's read register drives the output.

The split depends on a mapping mode. In low-order interleaving, the bank number comes from the least significant address bits, so consecutive addresses rotate through the banks. In high-order interleaving, the bank number comes from the most significant address bits, so consecutive addresses stay inside one bank.

The mode is held in a two-state controller:
- `MAP_LOW` (reset state) and `MAP_HIGH` are its two states.
- Transition `GO_HIGH`: from `MAP_LOW` to `MAP_HIGH`, taken on a clock edge where `wr_en` is low and `hi_order_mode` is high.
- Transition `GO_LOW`: from `MAP_HIGH` to `MAP_LOW`, taken on a clock edge where `wr_en` is low and `hi_order_mode` is low.
- Otherwise the state holds.

Switching the mode moves no data. It only changes which physical word each address names.

The bank count and the bank depth are parameters, both powers of two. The defaults are 16 banks of 32 bytes, which gives a 9-bit address. Other settings work the same way, for example 16 banks of 2048 bytes (15-bit address) or 8 banks of 16 bytes (7-bit address).

Top module: `imb_banked_mem`

## Requirements
- R1: After reset `rd_data` is 0 and the controller is in `MAP_LOW`. Holding `hi_order_mode` high during reset and during the first writes does not change that.
- R2: In `MAP_LOW`, the bank is `addr[3:0]` and the offset is `addr[8:4]` (defaults). Addresses 0 to 15 therefore land in banks 0 to 15 at offset 0.
- R3: In `MAP_HIGH`, the bank is `addr[8:5]` and the offset is `addr[4:0]` (defaults). Addresses 0 to 15 therefore land in bank 0 at offsets 0 to 15.
- R4: A write takes place only on a clock edge with `wr_en` high. It enables exactly one bank and changes only the addressed word. With `wr_en` low, `wr_data` has no effect on any word.
- R5: Reads have one cycle of latency. `rd_data` shows the byte at the address presented on the previous clock edge.
- R6: A write and a read of the same address on the same edge return the old byte. The new byte is returned from the next edge on.
- R7: `hi_order_mode` is sampled only on edges with `wr_en` low, and the new mapping applies from the following cycle. While `wr_en` is high, the mode input is ignored.
- R8: Changing the mode re-maps existing contents without moving them. A byte written through one mapping is found, through the other mapping, at the address that names the same bank and offset.
- R9: At most one bank write enable is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all storage |
| rst_n | input | 1 | Active-low synchronous reset of the controller and read registers |
| hi_order_mode | input | 1 | Requested mapping: 1 high-order, 0 low-order |
| addr | input | ADDR_W (9) | Byte address, 0 to total size minus 1 |
| wr_en | input | 1 | Write enable for the current edge |
| wr_data | input | DATA_W (8) | Byte to store |
| rd_data | output | DATA_W (8) | Byte read at the address from the previous edge |

## Verification
The assertions take the following for granted:
- The bank count and the bank depth are powers of two, so every address value names a real word.
- `wr_en` and `hi_order_mode` are at known levels at every edge after reset.

The stimulus keeps to this:
- It uses only in-range addresses.
- It drives every input at the falling edge.
- It changes `hi_order_mode` both in cycles that write, where the change must be ignored, and in cycles that only read, where it must take effect.
- It fills the whole memory before reading, so every expected byte is defined.

// File: rtl/imb_pkg.sv
package imb_pkg;

    // Mapping state: which address bits pick the bank.
    typedef enum logic {
        MAP_LOW  = 1'b0,
        MAP_HIGH = 1'b1
    } map_state_e;

endpackage

// File: rtl/imb_map_fsm.sv
module imb_map_fsm
    import imb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic mode_req,
    output logic map_hi
);

    map_state_e state_q;
    map_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MAP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: the mode request is only looked at when no write is under way.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_LOW: begin
                if (!wr_en && mode_req) begin
                    state_d = MAP_HIGH;   // GO_HIGH
                end
            end
            MAP_HIGH: begin
                if (!wr_en && !mode_req) begin
                    state_d = MAP_LOW;    // GO_LOW
                end
            end
            default: state_d = MAP_LOW;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            MAP_HIGH: map_hi = 1'b1;
            default:  map_hi = 1'b0;
        endcase
    end

endmodule

// File: rtl/imb_addr_decode.sv
module imb_addr_decode #(
    parameter int NUM_BANKS = 16,
    parameter int BSEL_W    = 4,
    parameter int OFF_W     = 5,
    localparam int ADDR_W   = BSEL_W + OFF_W
) (
    input  logic                 map_hi,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [BSEL_W-1:0]    bank,
    output logic [OFF_W-1:0]     offset,
    output logic [NUM_BANKS-1:0] bank_we
);

    logic [BSEL_W-1:0] bank_lo;
    logic [OFF_W-1:0]  off_lo;
    logic [BSEL_W-1:0] bank_hi;
    logic [OFF_W-1:0]  off_hi;

    // Low-order split: bank from the bottom bits, offset from the rest.
    assign bank_lo = addr[BSEL_W-1:0];
    assign off_lo  = addr[ADDR_W-1:BSEL_W];

    // High-order split: bank from the top bits, offset from the rest.
    assign bank_hi = addr[ADDR_W-1:OFF_W];
    assign off_hi  = addr[OFF_W-1:0];

    always_comb begin
        if (map_hi) begin
            bank   = bank_hi;
            offset = off_hi;
        end else begin
            bank   = bank_lo;
            offset = off_lo;
        end
    end

    // One write enable per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign bank_we[b] = wr_en && (bank == BSEL_W'(b));
    end

endmodule

// File: rtl/imb_bank.sv
module imb_bank #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int OFF_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: per-word enable, shared clock.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[offset] <= wdata;
        end
    end

    // Read register: sees the word before this edge's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[offset];
        end
    end

endmodule

// File: rtl/imb_read_mux.sv
module imb_read_mux #(
    parameter int NUM_BANKS = 16,
    parameter int DATA_W    = 8,
    localparam int BSEL_W   = $clog2(NUM_BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [BSEL_W-1:0]                 bank_in,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata,
    output logic [BSEL_W-1:0]                 sel_q,
    output logic [DATA_W-1:0]                 rd_data
);

    // Bank number registered alongside the banks' read registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= bank_in;
        end
    end

    assign rd_data = bank_rdata[sel_q];

endmodule

// File: rtl/imb_banked_mem.sv
module imb_banked_mem #(
    parameter int NUM_BANKS  = 16,
    parameter int BANK_DEPTH = 32,
    parameter int DATA_W     = 8,
    localparam int BSEL_W    = $clog2(NUM_BANKS),
    localparam int OFF_W     = $clog2(BANK_DEPTH),
    localparam int ADDR_W    = BSEL_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_order_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic                             map_hi;
    logic [BSEL_W-1:0]                dec_bank;
    logic [OFF_W-1:0]                 dec_off;
    logic [NUM_BANKS-1:0]             bank_we;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [BSEL_W-1:0]                sel_q;

    imb_map_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .mode_req (hi_order_mode),
        .map_hi   (map_hi)
    );

    imb_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BSEL_W    (BSEL_W),
        .OFF_W     (OFF_W)
    ) u_dec (
        .map_hi  (map_hi),
        .wr_en   (wr_en),
        .addr    (addr),
        .bank    (dec_bank),
        .offset  (dec_off),
        .bank_we (bank_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        imb_bank #(
            .DEPTH  (BANK_DEPTH),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (bank_we[b]),
            .offset (dec_off),
            .wdata  (wr_data),
            .rdata  (bank_rdata[b])
        );
    end

    imb_read_mux #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_in    (dec_bank),
        .bank_rdata (bank_rdata),
        .sel_q      (sel_q),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/imb_banked_mem_chk.sv
module imb_banked_mem_chk #(
    parameter int NUM_BANKS = 16,
    parameter int BSEL_W    = 4,
    parameter int OFF_W     = 5,
    localparam int ADDR_W   = BSEL_W + OFF_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 hi_order_mode,
    input logic                 map_hi,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_BANKS-1:0] bank_we,
    input logic [BSEL_W-1:0]    dec_bank,
    input logic [BSEL_W-1:0]    sel_q
);

    localparam logic [NUM_BANKS-1:0] ONE = NUM_BANKS'(1);

    // R1
    reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !map_hi);

    // R2
    low_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !map_hi) |-> (bank_we == (ONE << addr[BSEL_W-1:0])));

    // R3
    high_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && map_hi) |-> (bank_we == (ONE << addr[ADDR_W-1:OFF_W])));

    // R4
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (bank_we == '0));

    // R4
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(bank_we) == 1));

    // R5
    sel_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |=> (sel_q == $past(dec_bank)));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(map_hi));

    // R7
    mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (map_hi == $past(hi_order_mode)));

    // R9
    onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

endmodule

bind imb_banked_mem imb_banked_mem_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BSEL_W    (BSEL_W),
    .OFF_W     (OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .hi_order_mode (hi_order_mode),
    .map_hi        (map_hi),
    .addr          (addr),
    .bank_we       (bank_we),
    .dec_bank      (dec_bank),
    .sel_q         (sel_q)
);

// File: tb/test_imb_banked_mem.sv
module test_imb_banked_mem;

    localparam int NB = 16;
    localparam int DP = 32;
    localparam int BW = 4;
    localparam int OW = 5;
    localparam int AW = 9;
    localparam int SZ = NB * DP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_order_mode = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b1;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;

    always #4 clk = ~clk;

    imb_banked_mem i_imb_banked_mem (
        .clk           (clk),
        .rst_n         (rst_n),
        .hi_order_mode (hi_order_mode),
        .addr          (addr),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data)
    );

    typedef struct {
        logic [7:0]    data;
        logic [AW-1:0] a;
        string         tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] model [NB][DP];
    bit         cur_hi = 1'b0;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    // Bank and offset as stated in R2 and R3.
    function automatic int bank_of(input logic [AW-1:0] a, input bit hi);
        return hi ? int'(a[AW-1:OW]) : int'(a[BW-1:0]);
    endfunction

    function automatic int off_of(input logic [AW-1:0] a, input bit hi);
        return hi ? int'(a[OW-1:0]) : int'(a[AW-1:BW]);
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    // Driver: one access per cycle, expected read pushed to the scoreboard.
    task automatic op(input logic [AW-1:0] a, input logic w, input logic [7:0] d,
                      input logic m, input bit chk, input string tag);
        int b;
        int o;
        @(negedge clk);
        addr = a;
        wr_en = w;
        wr_data = d;
        hi_order_mode = m;
        b = bank_of(a, cur_hi);
        o = off_of(a, cur_hi);
        if (chk) exp_q.push_back('{data: model[b][o], a: a, tag: tag});
        if (w) model[b][o] = d;
        if (!w) cur_hi = m;
    endtask

    // Monitor: compares one cycle after each checked access.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            total++;
            if (rd_data !== it.data) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                         it.tag, it.a, rd_data, it.data);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: read output cleared by reset
        total++;
        if (rd_data !== 8'h00) begin
            bad++;
            $display("FAIL R1 reset actual=%02h expected=00", rd_data);
        end
        // Edge right after reset writes addr 0 with 0 in low mapping.
        model[0][0] = 8'h00;

        // R1/R7: fill with the mode input held high while writing: stays low-order.
        for (int a = 0; a < SZ; a++) op(AW'(a), 1'b1, pat(a), 1'b1, 1'b0, "R1");

        // R2: low-order, addresses 0..15 are banks 0..15 at offset 0.
        for (int a = 0; a < 16; a++) op(AW'(a), 1'b0, 8'h00, 1'b0, 1'b1, "R2");

        // R7/R8: switch to high-order on a read cycle, contents stay in place.
        op(AW'(3), 1'b0, 8'h00, 1'b1, 1'b1, "R7");
        for (int a = 0; a < 16; a++) op(AW'(a), 1'b0, 8'h00, 1'b1, 1'b1, "R3");
        for (int a = 0; a < 24; a++) op(AW'(a * 21 + 5), 1'b0, 8'h00, 1'b1, 1'b1, "R8");

        // R4: idle cycles with garbage data must not change anything.
        for (int a = 40; a < 48; a++) op(AW'(a), 1'b0, 8'hFF, 1'b1, 1'b0, "R4");
        for (int a = 40; a < 48; a++) op(AW'(a), 1'b0, 8'h00, 1'b1, 1'b1, "R4");

        // R6: write and read same address together, then read again (R5).
        op(AW'(100), 1'b1, 8'h3C, 1'b1, 1'b1, "R6");
        op(AW'(100), 1'b0, 8'h00, 1'b1, 1'b1, "R5");
        op(AW'(101), 1'b1, 8'hC3, 1'b1, 1'b1, "R6");
        op(AW'(101), 1'b0, 8'h00, 1'b1, 1'b1, "R5");

        // R7: mode input low during writes is ignored; mapping stays high-order.
        for (int a = 200; a < 206; a++) op(AW'(a), 1'b1, pat(a + 3), 1'b0, 1'b0, "R7");
        for (int a = 200; a < 206; a++) op(AW'(a), 1'b0, 8'h00, 1'b1, 1'b1, "R7");

        // R8/R5: back to low-order, scattered reads and back-to-back accesses.
        op(AW'(0), 1'b0, 8'h00, 1'b0, 1'b1, "R8");
        for (int a = 0; a < 40; a++) op(AW'(a * 13 + 7), 1'b0, 8'h00, 1'b0, 1'b1, "R5");
        for (int a = 200; a < 206; a++) op(AW'(a), 1'b0, 8'h00, 1'b0, 1'b1, "R8");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule